// File: doc/BRIEF.md
# Stored-Pattern Scan Test Player

This block acts as a master on a four-wire scan test bus. A small pattern memory holds one word per half period of the test clock. Each word sets the levels of the clock, mode-select and data-in lines that go to the first device of a scan chain. It also holds the response bit expected back from the last device, and a flag that says whether that response matters. The clock is not generated here: it is one column of the pattern, so a full test-clock period always takes two consecutive words. The memory is filled through a simple write port. After a start pulse, the player walks through a programmed number of words and holds each one for a programmable number of system clocks.

On the last system clock of each hold, the player samples the returning data line and compares it with the word's expected bit, unless the word marks the response as don't-care. The first failing word index is latched, and every mismatch increments a saturating error counter. A done flag and a pass flag summarise the run.

A master-mode input selects, pin by pin, between the scan master and ordinary general-purpose signals. While idle in master mode, the scan lines rest in a state that keeps attached TAP controllers still.

Top module: `scan_pattern_player`

## Requirements
- R1: A write with `wrEn` high stores `wrData` at `wrAddr`. The word fields are: bit 4 = clock level, bit 3 = mode-select level, bit 2 = data-in level, bit 1 = expected response, bit 0 = compare enable.
- R2: `start` is taken only while `masterMode` is 1. It clears the entry pointer, the error counter, the first-fail record and `done`. A start with `entryCount` 0 sets `done` on the next clock and plays nothing.
- R3: While busy in master mode, each word drives its three levels onto `pinTck`, `pinTms` and `pinTdi` for exactly `holdCycles`+1 system clocks. Words are played in address order from 0.
- R4: On the last clock of a word's hold, `pinTdo` is sampled. If the word's compare enable is 1 and the sample differs from the expected bit, one mismatch is recorded.
- R5: A word whose compare enable is 0 never records a mismatch, whatever `pinTdo` does.
- R6: The index of the first mismatching word is latched with `firstFailValid`. Later mismatches leave it unchanged.
- R7: `errCount` counts mismatches and saturates at its all-ones value.
- R8: After min(`entryCount`, memory depth) words, `busy` falls and `done` rises in the same cycle. `pass` equals `done` with no mismatch recorded.
- R9: In master mode when not busy, the pins rest at clock 0, mode-select 1 and data-in 1.
- R10: With `masterMode` 0, `pinTck`/`pinTms`/`pinTdi` follow `gpioDrv` bits 2/1/0 and `gpioTdo` follows `pinTdo`. With `masterMode` 1, `gpioTdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| masterMode | input | 1 | 1 routes pins to the scan master, 0 to general-purpose I/O |
| start | input | 1 | Begin a run |
| entryCount | input | ADDR_W+1 | Number of words to play |
| holdCycles | input | DIV_W | Extra system clocks each word is held |
| wrEn | input | 1 | Pattern memory write strobe |
| wrAddr | input | ADDR_W | Pattern memory write address |
| wrData | input | 5 | Pattern word |
| gpioDrv | input | 3 | General-purpose levels for the three output pins |
| pinTdo | input | 1 | Response line from the last chain device |
| pinTck | output | 1 | Test clock pin |
| pinTms | output | 1 | Mode-select pin |
| pinTdi | output | 1 | Data pin to the first chain device |
| gpioTdo | output | 1 | Response pin seen as general-purpose input |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with no mismatch |
| firstFailValid | output | 1 | A mismatch has been recorded |
| firstFailIdx | output | ADDR_W | Index of the first mismatching word |
| errCount | output | ERR_W | Saturating mismatch count |

## Verification
The response line is looped back from the driven data line, so the expected bits in a pattern decide which words mismatch. All-agreeing patterns show that the comparison accepts correct responses. Random patterns with mixed compare enables and hold lengths separate the first-fail latch from the count, and show whether the sample lands in the right word. A pattern that disagrees everywhere but has compare disabled isolates the don't-care path. A long fully mismatching run, a zero count and an oversize count cover saturation and the edges of the length logic. The general-purpose mode is checked with forced pin levels.

// File: rtl/scanplay_pkg.sv
package scanplay_pkg;
  localparam int unsigned WORD_W = 5;
  localparam int unsigned B_TCK = 4;
  localparam int unsigned B_TMS = 3;
  localparam int unsigned B_TDI = 2;
  localparam int unsigned B_EXP = 1;
  localparam int unsigned B_CMP = 0;

  typedef struct packed {
    logic clear;   // start accepted
    logic sample;  // last clock of a word's hold
    logic run;     // playback active
  } strobe_t;
endpackage

// File: rtl/scanplay_ctrl.sv
module scanplay_ctrl
  import scanplay_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              start,
  input  logic [ADDR_W:0]   entryCount,
  input  logic [DIV_W-1:0]  holdCycles,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] ptr,
  output strobe_t           strobe
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] DEPTH_V = DEPTH[ADDR_W:0];
  localparam logic [ADDR_W:0] ONE_C = 1;
  localparam logic [ADDR_W-1:0] ONE_A = 1;
  localparam logic [DIV_W-1:0] ONE_D = 1;

  logic [DIV_W-1:0] holdCnt;
  logic [ADDR_W:0] effCount;
  logic [ADDR_W:0] lastIdx;
  logic accept;
  logic holdEnd;

  assign effCount = (entryCount > DEPTH_V) ? DEPTH_V : entryCount;
  assign lastIdx  = effCount - ONE_C;
  assign accept   = start && masterMode;
  assign holdEnd  = (holdCnt == holdCycles);

  assign strobe.clear  = accept;
  assign strobe.sample = busy && holdEnd && !accept;
  assign strobe.run    = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      ptr     <= '0;
      holdCnt <= '0;
    end else if (accept) begin
      ptr     <= '0;
      holdCnt <= '0;
      busy    <= (effCount != '0);
      done    <= (effCount == '0);
    end else if (busy) begin
      if (holdEnd) begin
        holdCnt <= '0;
        if ({1'b0, ptr} == lastIdx) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          ptr <= ptr + ONE_A;
        end
      end else begin
        holdCnt <= holdCnt + ONE_D;
      end
    end
  end

  assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy && !strobe.sample && !strobe.clear |=> $stable(ptr) && busy);

  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    start && !masterMode && !busy |=> !busy);
endmodule

// File: rtl/scanplay_dp.sv
module scanplay_dp
  import scanplay_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned ERR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] ptr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [2:0]        gpioDrv,
  input  logic              pinTdo,
  output logic              pinTck,
  output logic              pinTms,
  output logic              pinTdi,
  output logic              gpioTdo,
  output logic              firstFailValid,
  output logic [ADDR_W-1:0] firstFailIdx,
  output logic [ERR_W-1:0]  errCount
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;
  localparam logic [ERR_W-1:0] ONE_E = 1;

  logic [WORD_W-1:0] patMem [DEPTH];
  logic [WORD_W-1:0] curWord;
  logic mismatch;
  logic scanTck, scanTms, scanTdi;

  always_ff @(posedge clk) begin
    if (wrEn) patMem[wrAddr] <= wrData;
  end

  assign curWord  = patMem[ptr];
  assign mismatch = strobe.sample && curWord[B_CMP] && (pinTdo != curWord[B_EXP]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCount       <= '0;
      firstFailValid <= 1'b0;
      firstFailIdx   <= '0;
    end else if (strobe.clear) begin
      errCount       <= '0;
      firstFailValid <= 1'b0;
      firstFailIdx   <= '0;
    end else if (mismatch) begin
      if (errCount != ERR_MAX) errCount <= errCount + ONE_E;
      if (!firstFailValid) begin
        firstFailValid <= 1'b1;
        firstFailIdx   <= ptr;
      end
    end
  end

  // scan lines rest at clock low, mode-select high, data high when idle
  assign scanTck = strobe.run ? curWord[B_TCK] : 1'b0;
  assign scanTms = strobe.run ? curWord[B_TMS] : 1'b1;
  assign scanTdi = strobe.run ? curWord[B_TDI] : 1'b1;

  assign pinTck  = masterMode ? scanTck : gpioDrv[2];
  assign pinTms  = masterMode ? scanTms : gpioDrv[1];
  assign pinTdi  = masterMode ? scanTdi : gpioDrv[0];
  assign gpioTdo = masterMode ? 1'b0 : pinTdo;

  assert_err_sat_R7: assert property (@(posedge clk) disable iff (!rstN)
    errCount == ERR_MAX && !strobe.clear |=> errCount == ERR_MAX);

  assert_err_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clear |=> (errCount == $past(errCount)) || (errCount == $past(errCount) + ONE_E));

  assert_first_fail_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    firstFailValid && !strobe.clear |=> firstFailValid && $stable(firstFailIdx));

  assert_dont_care_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sample && !curWord[B_CMP] |=> $stable(errCount) && $stable(firstFailValid));
endmodule

// File: rtl/scan_pattern_player.sv
module scan_pattern_player
  import scanplay_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DIV_W = 8,
  parameter int unsigned ERR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              start,
  input  logic [ADDR_W:0]   entryCount,
  input  logic [DIV_W-1:0]  holdCycles,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [4:0]        wrData,
  input  logic [2:0]        gpioDrv,
  input  logic              pinTdo,
  output logic              pinTck,
  output logic              pinTms,
  output logic              pinTdi,
  output logic              gpioTdo,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              firstFailValid,
  output logic [ADDR_W-1:0] firstFailIdx,
  output logic [ERR_W-1:0]  errCount
);
  strobe_t strobe;
  logic [ADDR_W-1:0] ptr;

  scanplay_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .start(start),
    .entryCount(entryCount), .holdCycles(holdCycles),
    .busy(busy), .done(done), .ptr(ptr), .strobe(strobe)
  );

  scanplay_dp #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) uDp (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .strobe(strobe), .ptr(ptr),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .gpioDrv(gpioDrv),
    .pinTdo(pinTdo), .pinTck(pinTck), .pinTms(pinTms), .pinTdi(pinTdi),
    .gpioTdo(gpioTdo), .firstFailValid(firstFailValid),
    .firstFailIdx(firstFailIdx), .errCount(errCount)
  );

  assign pass = done && !firstFailValid;
endmodule

// File: tb/sim_scan_pattern_player.sv
module sim_scan_pattern_player;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int EW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int EMAX = (1 << EW) - 1;

  logic clk = 0, rstN = 0, masterMode = 1, start = 0, wrEn = 0;
  logic [AW:0] entryCount = '0;
  logic [DW-1:0] holdCycles = '0;
  logic [AW-1:0] wrAddr = '0;
  logic [4:0] wrData = '0;
  logic [2:0] gpioDrv = '0;
  logic forceTdo = 0, forceVal = 0;
  logic pinTdo, pinTck, pinTms, pinTdi, gpioTdo, busy, done, pass, firstFailValid;
  logic [AW-1:0] firstFailIdx;
  logic [EW-1:0] errCount;

  int nChecks = 0, nFails = 0;
  logic [4:0] pat [DEPTH];

  assign pinTdo = forceTdo ? forceVal : pinTdi;  // loopback chain

  always #(CLK_P/2) clk = ~clk;

  scan_pattern_player #(.ADDR_W(AW), .DIV_W(DW), .ERR_W(EW)) u0 (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .start(start),
    .entryCount(entryCount), .holdCycles(holdCycles), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .gpioDrv(gpioDrv), .pinTdo(pinTdo),
    .pinTck(pinTck), .pinTms(pinTms), .pinTdi(pinTdi), .gpioTdo(gpioTdo),
    .busy(busy), .done(done), .pass(pass), .firstFailValid(firstFailValid),
    .firstFailIdx(firstFailIdx), .errCount(errCount)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic loadPat(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 1; wrAddr = i[AW-1:0]; wrData = pat[i];
    end
    @(negedge clk);
    wrEn = 0;
  endtask

  // expected outcome with loopback: a word mismatches when compare is on and exp != tdi
  function automatic int expErrs(input int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (pat[i][0] && (pat[i][1] != pat[i][2])) c++;
    return c;
  endfunction

  function automatic int expFirst(input int n);
    for (int i = 0; i < n; i++) if (pat[i][0] && (pat[i][1] != pat[i][2])) return i;
    return -1;
  endfunction

  task automatic play(input int n, input int h, output int cyc, output bit pinsOk);
    entryCount = n[AW:0]; holdCycles = h[DW-1:0];
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    cyc = 0; pinsOk = 1;
    while (busy) begin
      int idx = cyc / (h + 1);
      if (idx >= DEPTH || {pinTck, pinTms, pinTdi} != pat[idx][4:2]) pinsOk = 0;
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic runAndCheck(input int n, input int h, input string tag);
    int cyc, eff, e, f;
    bit pinsOk;
    eff = (n > DEPTH) ? DEPTH : n;
    e = expErrs(eff); f = expFirst(eff);
    play(n, h, cyc, pinsOk);
    chk(cyc == eff * (h + 1), {tag, " R3 hold length"}, cyc, eff * (h + 1));
    chk(pinsOk, {tag, " R3 pin levels"}, pinsOk, 1);
    chk(done && !busy, {tag, " R8 done"}, done, 1);
    chk(int'(errCount) == ((e > EMAX) ? EMAX : e), {tag, " R4 R7 errCount"},
        int'(errCount), (e > EMAX) ? EMAX : e);
    chk(pass == (e == 0), {tag, " R8 pass"}, pass, e == 0);
    chk(firstFailValid == (f >= 0), {tag, " R6 firstFailValid"}, firstFailValid, f >= 0);
    if (f >= 0) chk(int'(firstFailIdx) == f, {tag, " R6 firstFailIdx"}, int'(firstFailIdx), f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int cyc;
    bit pinsOk;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !done && errCount == 0, "reset state", {busy, done}, 0);
    chk({pinTck, pinTms, pinTdi} == 3'b011, "R9 idle pins", {pinTck, pinTms, pinTdi}, 3);

    // R10 general-purpose mode
    masterMode = 0; forceTdo = 1;
    for (int k = 0; k < 8; k++) begin
      gpioDrv = k[2:0]; forceVal = k[0];
      @(negedge clk);
      chk({pinTck, pinTms, pinTdi} == k[2:0] && gpioTdo == k[0], "R10 gpio route",
          {pinTck, pinTms, pinTdi, gpioTdo}, {k[2:0], k[0]});
    end
    // R2 start ignored when not in master mode
    entryCount = 4; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    chk(!busy && !done, "R2 start ignored in gpio mode", {busy, done}, 0);
    masterMode = 1;
    @(negedge clk);
    chk(gpioTdo == 0, "R10 gpioTdo zero in master mode", gpioTdo, 0);
    forceTdo = 0;

    // R1 R8 all-agree pattern
    for (int i = 0; i < DEPTH; i++) begin
      pat[i][4:2] = 3'($urandom);
      pat[i][1] = pat[i][2];
      pat[i][0] = 1'b1;
    end
    loadPat(DEPTH);
    runAndCheck(8, 0, "R1 agree");
    chk({pinTck, pinTms, pinTdi} == 3'b011, "R9 idle after run", {pinTck, pinTms, pinTdi}, 3);

    // R5 compare disabled on all-disagreeing words
    for (int i = 0; i < 16; i++) begin
      pat[i][4:2] = 3'($urandom);
      pat[i][1] = ~pat[i][2];
      pat[i][0] = 1'b0;
    end
    loadPat(16);
    runAndCheck(16, 1, "R5 dont care");

    // random runs
    for (int r = 0; r < 8; r++) begin
      int n = 1 + ($urandom % DEPTH);
      int h = $urandom % 4;
      for (int i = 0; i < DEPTH; i++) pat[i] = 5'($urandom);
      loadPat(DEPTH);
      runAndCheck(n, h, "R4 random");
    end

    // R7 saturation and R6 first index on a fully mismatching run
    for (int i = 0; i < 40; i++) begin
      pat[i][4:2] = 3'($urandom);
      pat[i][1] = ~pat[i][2];
      pat[i][0] = 1'b1;
    end
    loadPat(40);
    runAndCheck(40, 0, "R7 saturate");

    // R2 zero count and clear of previous failures
    entryCount = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(done && !busy && errCount == 0 && !firstFailValid && pass, "R2 zero count",
        {done, busy, firstFailValid}, 3'b100);

    // R8 oversize count clamps to depth
    for (int i = 0; i < DEPTH; i++) pat[i] = 5'($urandom);
    loadPat(DEPTH);
    runAndCheck(DEPTH + 20, 2, "R8 clamp");

    play(0, 0, cyc, pinsOk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule